// File: doc/BRIEF.md
# Serial Motor-Command Target Register File

This block is the memory-mapped register bank of a serial motor-command target. A host processor reaches it through an AXI-Lite slave port. The registers hold the target enable, the reply enable, the reply payload word, an external mux select and four timing values used by the line decoder and the reply transmitter. The block also keeps three event counters and sticky status flags. A registered interrupt is taken from the status flags after masking. A receive FIFO that sits outside the block is read through a pop window, a status word and an occupancy word.

Writing the control register normally loads all four timing registers from a built-in table of eight presets. Each preset scales one base bit period. A preserve bit in the same write leaves the timing registers as they are, so software can keep values it wrote by hand. The decoder and the transmitter are outside this block. They report events on single-cycle strobes and read their settings from the block's outputs.

Top module: `motor_cmd_regfile`

## Requirements
- R1: After reset, the following read as zero: control, mask, payload, mux select, status flags, counters and the interrupt. The four timing registers hold preset 0.
- R2: The mask (0x08, bits 3:0), payload (0x0C, bits 15:0), mux select (0x10, bit 0) and timing registers (0x14 threshold, 0x18 reply delay, 0x1C reply bit clocks, 0x20 frame timeout, each 16 bits) can be written and read back. The payload drives reply_word_o and mux bit 0 drives mux_sel_o.
- R3: In control (0x00), bit 0 drives enable_o, bit 1 drives bidir_en_o, bits 4:2 are a preset code p and bit 5 is a preserve flag. A control write with bit 5 clear loads the timing registers from preset p. With B = 400 >> p, the values are: threshold B/2, reply delay 4*B, reply bit clocks (4*B)/5 and frame timeout 20*B, using integer division.
- R4: A control write with bit 5 set leaves all four timing registers unchanged. Bits 5:0 still read back exactly as written.
- R5: Status (0x04) reads as follows: bit 0 is the live busy_i, bit 1 is reply-sent, bit 2 is FIFO overflow and bit 3 is frame timeout. Each of bits 1 to 3 is set on the clock edge after its strobe and then stays set.
- R6: Writing 1 to a status bit in 1..3 clears that bit, and writing 0 has no effect. A strobe on the same edge as the clear wins, so the bit stays set.
- R7: irq_o is registered. It goes high one cycle after any status bit (including busy) is high together with the matching mask bit. Control bit 31 reads the current irq_o.
- R8: The counters at 0x24 (good frames), 0x28 (replies sent) and 0x2C (CRC-error frames) each add one per strobe cycle and wrap modulo 2^32. Writes to them are ignored.
- R9: A read of 0x30 returns the FIFO head entry zero-extended and raises fifo_pop_o for the handshake cycle. If the FIFO is empty, the read returns 0 and no pop occurs. 0x34 reads {full, empty} in bits 1:0, and 0x38 reads the occupancy.
- R10: The write address and write data may arrive in either order or together. Every response is OKAY (0). Unmapped reads return 0 and unmapped writes change nothing. bvalid and rvalid, together with read data, stay stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | AW | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | AW | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| busy_i | input | 1 | Live busy flag from the datapath |
| reply_sent_i | input | 1 | Strobe: reply finished |
| fifo_ovf_i | input | 1 | Strobe: receive FIFO overflow |
| frame_tmo_i | input | 1 | Strobe: frame timeout |
| good_frame_i | input | 1 | Strobe: good frame decoded |
| crc_err_i | input | 1 | Strobe: frame with CRC error |
| fifo_head_i | input | FW | Receive FIFO head entry |
| fifo_empty_i | input | 1 | Receive FIFO empty |
| fifo_full_i | input | 1 | Receive FIFO full |
| fifo_level_i | input | OW | Receive FIFO occupancy |
| fifo_pop_o | output | 1 | Pop request to the FIFO |
| enable_o | output | 1 | Target enable |
| bidir_en_o | output | 1 | Reply enable |
| pulse_thr_o | output | TW | Pulse-width threshold |
| reply_dly_o | output | TW | Reply turnaround delay |
| reply_bit_o | output | TW | Reply bit clocks |
| frame_tmo_o | output | TW | Frame timeout |
| reply_word_o | output | 16 | Reply payload word |
| mux_sel_o | output | 1 | External mux select |
| irq_o | output | 1 | Registered interrupt |

## Verification
The assertions assume that each event strobe is a synchronous level sampled on every edge. They also assume that the AXI master keeps its valid signals and payload stable until the handshake. The bench follows both rules. It raises and lowers every input one time unit after a rising edge, and it holds each valid until it sees ready at the preceding falling edge. The bench keeps bready and rready high and makes reads only while the strobes are quiet. Because of this, each read has one well-defined expected value. The one deliberate overlap is a held overflow strobe that runs through a write-one-to-clear.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned NPRE = 8;
  localparam int unsigned PSW  = $clog2(NPRE);
  localparam int unsigned NST  = 3;   // sticky flags: reply, overflow, timeout
  localparam int unsigned NCNT = 3;   // good, reply, crc

  // word indices (byte offset / 4)
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_STAT  = 1;
  localparam int unsigned IDX_MASK  = 2;
  localparam int unsigned IDX_PAY   = 3;
  localparam int unsigned IDX_MUX   = 4;
  localparam int unsigned IDX_THR   = 5;
  localparam int unsigned IDX_DLY   = 6;
  localparam int unsigned IDX_RBIT  = 7;
  localparam int unsigned IDX_TMO   = 8;
  localparam int unsigned IDX_CGOOD = 9;
  localparam int unsigned IDX_CREP  = 10;
  localparam int unsigned IDX_CCRC  = 11;
  localparam int unsigned IDX_FPOP  = 12;
  localparam int unsigned IDX_FSTAT = 13;
  localparam int unsigned IDX_FOCC  = 14;

  typedef struct packed {
    logic           keep;
    logic [PSW-1:0] preset;
    logic           bidir;
    logic           en;
  } ctrl_t;

  function automatic int pre_bit(int base, int p);
    return base >> p;
  endfunction
  function automatic int pre_thr(int base, int p);
    return pre_bit(base, p) / 2;
  endfunction
  function automatic int pre_dly(int base, int p);
    return 4 * pre_bit(base, p);
  endfunction
  function automatic int pre_rbit(int base, int p);
    return (4 * pre_bit(base, p)) / 5;
  endfunction
  function automatic int pre_tmo(int base, int p);
    return 20 * pre_bit(base, p);
  endfunction
endpackage

// File: rtl/mcr_preset_table.sv
module mcr_preset_table
  import mcr_pkg::*;
#(
  parameter int TW       = 16,
  parameter int BIT_BASE = 400
) (
  input  logic [PSW-1:0] sel_i,
  output logic [TW-1:0]  thr_o,
  output logic [TW-1:0]  dly_o,
  output logic [TW-1:0]  rbit_o,
  output logic [TW-1:0]  tmo_o
);
  logic [TW-1:0] thr_t  [NPRE];
  logic [TW-1:0] dly_t  [NPRE];
  logic [TW-1:0] rbit_t [NPRE];
  logic [TW-1:0] tmo_t  [NPRE];

  for (genvar p = 0; p < NPRE; p++) begin : g_pre
    assign thr_t[p]  = TW'(pre_thr(BIT_BASE, p));
    assign dly_t[p]  = TW'(pre_dly(BIT_BASE, p));
    assign rbit_t[p] = TW'(pre_rbit(BIT_BASE, p));
    assign tmo_t[p]  = TW'(pre_tmo(BIT_BASE, p));
  end

  assign thr_o  = thr_t[sel_i];
  assign dly_o  = dly_t[sel_i];
  assign rbit_o = rbit_t[sel_i];
  assign tmo_o  = tmo_t[sel_i];
endmodule

// File: rtl/mcr_sticky_irq.sv
module mcr_sticky_irq #(
  parameter int NS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          live_i,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  input  logic [NS:0]   mask_i,
  output logic [NS-1:0] sticky_o,
  output logic          irq_o
);
  logic [NS-1:0] sticky_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~clr_i) | set_i;  // set wins
      irq_q    <= |({sticky_q, live_i} & mask_i);
    end
  end

  assign sticky_o = sticky_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/mcr_counter.sv
module mcr_counter #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/motor_cmd_regfile.sv
module motor_cmd_regfile
  import mcr_pkg::*;
#(
  parameter int AW       = 8,
  parameter int TW       = 16,
  parameter int CW       = 32,
  parameter int FW       = 19,
  parameter int OW       = 6,
  parameter int BIT_BASE = 400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] s_awaddr_i,
  input  logic          s_awvalid_i,
  output logic          s_awready_o,
  input  logic [31:0]   s_wdata_i,
  input  logic          s_wvalid_i,
  output logic          s_wready_o,
  output logic [1:0]    s_bresp_o,
  output logic          s_bvalid_o,
  input  logic          s_bready_i,
  input  logic [AW-1:0] s_araddr_i,
  input  logic          s_arvalid_i,
  output logic          s_arready_o,
  output logic [31:0]   s_rdata_o,
  output logic [1:0]    s_rresp_o,
  output logic          s_rvalid_o,
  input  logic          s_rready_i,
  input  logic          busy_i,
  input  logic          reply_sent_i,
  input  logic          fifo_ovf_i,
  input  logic          frame_tmo_i,
  input  logic          good_frame_i,
  input  logic          crc_err_i,
  input  logic [FW-1:0] fifo_head_i,
  input  logic          fifo_empty_i,
  input  logic          fifo_full_i,
  input  logic [OW-1:0] fifo_level_i,
  output logic          fifo_pop_o,
  output logic          enable_o,
  output logic          bidir_en_o,
  output logic [TW-1:0] pulse_thr_o,
  output logic [TW-1:0] reply_dly_o,
  output logic [TW-1:0] reply_bit_o,
  output logic [TW-1:0] frame_tmo_o,
  output logic [15:0]   reply_word_o,
  output logic          mux_sel_o,
  output logic          irq_o
);
  localparam int IW  = AW - 2;
  localparam int WDW = (TW > 16) ? TW : 16;

  ctrl_t          ctrl_q;
  logic [NST:0]   mask_q;
  logic [15:0]    pay_q;
  logic           mux_q;
  logic [TW-1:0]  thr_q, dly_q, rbit_q, tmo_q;
  logic [TW-1:0]  p_thr, p_dly, p_rbit, p_tmo;
  logic [NST-1:0] sticky_vec, clr_vec;
  logic [CW-1:0]  cnt_q [NCNT];
  logic [NCNT-1:0] cnt_inc;

  // write channel capture
  logic           aw_full_q, w_full_q, bvalid_q;
  logic [IW-1:0]  aw_idx_q;
  logic [WDW-1:0] wdata_q;
  logic           wr_fire;

  logic unused_bits;
  assign unused_bits = ^{s_wdata_i[31:WDW], s_awaddr_i[1:0], s_araddr_i[1:0]};

  assign s_awready_o = ~aw_full_q;
  assign s_wready_o  = ~w_full_q;
  assign wr_fire     = aw_full_q & w_full_q & ~bvalid_q;
  assign s_bvalid_o  = bvalid_q;
  assign s_bresp_o   = 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      aw_idx_q  <= '0;
      wdata_q   <= '0;
    end else begin
      if (s_awvalid_i && s_awready_o) begin
        aw_full_q <= 1'b1;
        aw_idx_q  <= s_awaddr_i[AW-1:2];
      end else if (wr_fire) begin
        aw_full_q <= 1'b0;
      end
      if (s_wvalid_i && s_wready_o) begin
        w_full_q <= 1'b1;
        wdata_q  <= s_wdata_i[WDW-1:0];
      end else if (wr_fire) begin
        w_full_q <= 1'b0;
      end
      if (wr_fire)         bvalid_q <= 1'b1;
      else if (s_bready_i) bvalid_q <= 1'b0;
    end
  end

  mcr_preset_table #(.TW(TW), .BIT_BASE(BIT_BASE)) u_pre (
    .sel_i (wdata_q[PSW+1:2]),
    .thr_o (p_thr),
    .dly_o (p_dly),
    .rbit_o(p_rbit),
    .tmo_o (p_tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      pay_q  <= '0;
      mux_q  <= 1'b0;
      thr_q  <= TW'(pre_thr(BIT_BASE, 0));
      dly_q  <= TW'(pre_dly(BIT_BASE, 0));
      rbit_q <= TW'(pre_rbit(BIT_BASE, 0));
      tmo_q  <= TW'(pre_tmo(BIT_BASE, 0));
    end else if (wr_fire) begin
      case (aw_idx_q)
        IW'(IDX_CTRL): begin
          ctrl_q <= ctrl_t'(wdata_q[$bits(ctrl_t)-1:0]);
          if (!wdata_q[$bits(ctrl_t)-1]) begin
            thr_q  <= p_thr;
            dly_q  <= p_dly;
            rbit_q <= p_rbit;
            tmo_q  <= p_tmo;
          end
        end
        IW'(IDX_MASK): mask_q <= wdata_q[NST:0];
        IW'(IDX_PAY):  pay_q  <= wdata_q[15:0];
        IW'(IDX_MUX):  mux_q  <= wdata_q[0];
        IW'(IDX_THR):  thr_q  <= wdata_q[TW-1:0];
        IW'(IDX_DLY):  dly_q  <= wdata_q[TW-1:0];
        IW'(IDX_RBIT): rbit_q <= wdata_q[TW-1:0];
        IW'(IDX_TMO):  tmo_q  <= wdata_q[TW-1:0];
        default: ;
      endcase
    end
  end

  assign clr_vec = (wr_fire && aw_idx_q == IW'(IDX_STAT)) ? wdata_q[NST:1] : '0;

  mcr_sticky_irq #(.NS(NST)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .live_i  (busy_i),
    .set_i   ({frame_tmo_i, fifo_ovf_i, reply_sent_i}),
    .clr_i   (clr_vec),
    .mask_i  (mask_q),
    .sticky_o(sticky_vec),
    .irq_o   (irq_o)
  );

  assign cnt_inc = {crc_err_i, reply_sent_i, good_frame_i};
  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    mcr_counter #(.CW(CW)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (cnt_inc[c]),
      .cnt_o (cnt_q[c])
    );
  end

  // read channel
  logic          rvalid_q, ar_fire;
  logic [31:0]   rdata_q, rd_mux;
  logic [IW-1:0] ridx;

  assign s_arready_o = ~rvalid_q;
  assign ar_fire     = s_arvalid_i & s_arready_o;
  assign ridx        = s_araddr_i[AW-1:2];
  assign fifo_pop_o  = ar_fire && (ridx == IW'(IDX_FPOP)) && !fifo_empty_i;

  always_comb begin
    case (ridx)
      IW'(IDX_CTRL):  rd_mux = {irq_o, 25'd0, ctrl_q};
      IW'(IDX_STAT):  rd_mux = 32'({sticky_vec, busy_i});
      IW'(IDX_MASK):  rd_mux = 32'(mask_q);
      IW'(IDX_PAY):   rd_mux = 32'(pay_q);
      IW'(IDX_MUX):   rd_mux = 32'(mux_q);
      IW'(IDX_THR):   rd_mux = 32'(thr_q);
      IW'(IDX_DLY):   rd_mux = 32'(dly_q);
      IW'(IDX_RBIT):  rd_mux = 32'(rbit_q);
      IW'(IDX_TMO):   rd_mux = 32'(tmo_q);
      IW'(IDX_CGOOD): rd_mux = 32'(cnt_q[0]);
      IW'(IDX_CREP):  rd_mux = 32'(cnt_q[1]);
      IW'(IDX_CCRC):  rd_mux = 32'(cnt_q[2]);
      IW'(IDX_FPOP):  rd_mux = fifo_empty_i ? 32'd0 : 32'(fifo_head_i);
      IW'(IDX_FSTAT): rd_mux = 32'({fifo_full_i, fifo_empty_i});
      IW'(IDX_FOCC):  rd_mux = 32'(fifo_level_i);
      default:        rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (ar_fire) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_mux;
    end else if (s_rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign s_rvalid_o   = rvalid_q;
  assign s_rdata_o    = rdata_q;
  assign s_rresp_o    = 2'b00;

  assign enable_o     = ctrl_q.en;
  assign bidir_en_o   = ctrl_q.bidir;
  assign pulse_thr_o  = thr_q;
  assign reply_dly_o  = dly_q;
  assign reply_bit_o  = rbit_q;
  assign frame_tmo_o  = tmo_q;
  assign reply_word_o = pay_q;
  assign mux_sel_o    = mux_q;
endmodule

// File: rtl/motor_cmd_regfile_chk.sv
module motor_cmd_regfile_chk #(
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          busy_i,
  input logic          reply_sent_i,
  input logic          fifo_ovf_i,
  input logic          good_frame_i,
  input logic [2:0]    sticky_i,
  input logic [3:0]    mask_i,
  input logic [CW-1:0] cnt_good_i,
  input logic          s_bvalid_o,
  input logic          s_bready_i,
  input logic          s_rvalid_o,
  input logic          s_rready_i,
  input logic [31:0]   s_rdata_o,
  input logic          fifo_pop_o
);
  assert_irq_lag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|({sticky_i, busy_i} & mask_i)));

  assert_reply_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_sent_i |=> sticky_i[0]);

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ovf_i |=> sticky_i[1]);

  assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_frame_i |=> cnt_good_i == $past(cnt_good_i) + 1'b1);

  assert_bresp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o && !s_bready_i |=> s_bvalid_o);

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o && !s_rready_i |=> s_rvalid_o && $stable(s_rdata_o));

  assert_pop_resp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> s_rvalid_o);
endmodule

bind motor_cmd_regfile motor_cmd_regfile_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_o       (irq_o),
  .busy_i      (busy_i),
  .reply_sent_i(reply_sent_i),
  .fifo_ovf_i  (fifo_ovf_i),
  .good_frame_i(good_frame_i),
  .sticky_i    (sticky_vec),
  .mask_i      (mask_q),
  .cnt_good_i  (cnt_q[0]),
  .s_bvalid_o  (s_bvalid_o),
  .s_bready_i  (s_bready_i),
  .s_rvalid_o  (s_rvalid_o),
  .s_rready_i  (s_rready_i),
  .s_rdata_o   (s_rdata_o),
  .fifo_pop_o  (fifo_pop_o)
);

// File: tb/motor_cmd_regfile_tb.sv
`timescale 1ns/1ps
module motor_cmd_regfile_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0] wdata = '0;
  logic        busy = 0, rsent = 0, ovf = 0, tmo = 0, gf = 0, crc = 0;
  logic [18:0] head = '0;
  logic        fempty = 1, ffull = 0;
  logic [5:0]  flevel = '0;

  logic        awready, wready, bvalid, arready, rvalid, pop;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        en_o, bidir_o, mux_o, irq;
  logic [15:0] thr_o, dly_o, rbit_o, tmo_o, word_o;

  always #2.5 clk_i = ~clk_i;

  motor_cmd_regfile u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(1'b1),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(1'b1),
    .busy_i(busy), .reply_sent_i(rsent), .fifo_ovf_i(ovf), .frame_tmo_i(tmo),
    .good_frame_i(gf), .crc_err_i(crc),
    .fifo_head_i(head), .fifo_empty_i(fempty), .fifo_full_i(ffull),
    .fifo_level_i(flevel), .fifo_pop_o(pop),
    .enable_o(en_o), .bidir_en_o(bidir_o), .pulse_thr_o(thr_o),
    .reply_dly_o(dly_o), .reply_bit_o(rbit_o), .frame_tmo_o(tmo_o),
    .reply_word_o(word_o), .mux_sel_o(mux_o), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit [5:0]  m_ctrl;
  bit [3:0]  m_mask;
  bit [15:0] m_pay;
  bit        m_mux, m_irq, m_prevb;
  int        m_thr, m_dly, m_rbit, m_tmo;
  bit [2:0]  m_st;        // {timeout, overflow, reply}
  bit [31:0] m_cnt [3];   // good, reply, crc
  int        aq[$];
  bit [31:0] dq[$];
  bit s_rst, s_busy, s_rs, s_ov, s_to, s_gf, s_crc;

  function automatic void load_preset(int p);
    int b = 400 >> p;
    m_thr = b / 2; m_dly = 4 * b; m_rbit = (4 * b) / 5; m_tmo = 20 * b;
  endfunction

  function automatic void model_reset();
    m_ctrl = 0; m_mask = 0; m_pay = 0; m_mux = 0; m_irq = 0; m_prevb = 0;
    m_st = 0; m_cnt[0] = 0; m_cnt[1] = 0; m_cnt[2] = 0;
    load_preset(0);
  endfunction

  function automatic void model_step();
    bit irq_n;
    bit [2:0] clr = 0;
    int a;
    bit [31:0] d;
    irq_n = |({m_st, s_busy} & m_mask);
    if (bvalid && !m_prevb && aq.size() > 0) begin
      a = aq.pop_front(); d = dq.pop_front();
      case (a)
        'h00: begin m_ctrl = d[5:0]; if (!d[5]) load_preset(int'(d[4:2])); end
        'h04: clr = d[3:1];
        'h08: m_mask = d[3:0];
        'h0C: m_pay = d[15:0];
        'h10: m_mux = d[0];
        'h14: m_thr = int'(d[15:0]);
        'h18: m_dly = int'(d[15:0]);
        'h1C: m_rbit = int'(d[15:0]);
        'h20: m_tmo = int'(d[15:0]);
        default: ;
      endcase
    end
    m_st = (m_st & ~clr) | {s_to, s_ov, s_rs};
    m_cnt[0] += 32'(s_gf); m_cnt[1] += 32'(s_rs); m_cnt[2] += 32'(s_crc);
    m_prevb = bvalid;
    m_irq = irq_n;
  endfunction

  function automatic bit [31:0] model_read(int a);
    case (a)
      'h00: return {m_irq, 25'd0, m_ctrl};
      'h04: return {28'd0, m_st, busy};
      'h08: return 32'(m_mask);
      'h0C: return 32'(m_pay);
      'h10: return 32'(m_mux);
      'h14: return 32'(m_thr);
      'h18: return 32'(m_dly);
      'h1C: return 32'(m_rbit);
      'h20: return 32'(m_tmo);
      'h24: return m_cnt[0];
      'h28: return m_cnt[1];
      'h2C: return m_cnt[2];
      'h30: return fempty ? 32'd0 : 32'(head);
      'h34: return {30'd0, ffull, fempty};
      'h38: return 32'(flevel);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk_i) begin
    s_rst = rst_ni; s_busy = busy; s_rs = rsent; s_ov = ovf; s_to = tmo;
    s_gf = gf; s_crc = crc;
    #1.5;
    if (!s_rst) model_reset(); else model_step();
    check("R7", "irq_o", 64'(irq), 64'(m_irq));
    check("R2", "mux_sel_o", 64'(mux_o), 64'(m_mux));
    check("R2", "reply_word_o", 64'(word_o), 64'(m_pay));
    check("R3", "enable_o", 64'(en_o), 64'(m_ctrl[0]));
    check("R3", "bidir_en_o", 64'(bidir_o), 64'(m_ctrl[1]));
    check("R3", "pulse_thr_o", 64'(thr_o), 64'(m_thr));
    check("R3", "reply_dly_o", 64'(dly_o), 64'(m_dly));
    check("R3", "reply_bit_o", 64'(rbit_o), 64'(m_rbit));
    check("R3", "frame_tmo_o", 64'(tmo_o), 64'(m_tmo));
  end

  // ---------------- bus tasks ----------------
  // mode 0: together, 1: address first, 2: data first
  task automatic axi_write(string req, int a, bit [31:0] d, int mode);
    bit aw_done = 0, w_done = 0, aw_up = 0, w_up = 0;
    int cyc = 0;
    aq.push_back(a); dq.push_back(d);
    @(posedge clk_i); #1;
    awaddr = 8'(a); wdata = d;
    if (mode != 2) begin awvalid = 1; aw_up = 1; end
    if (mode != 1) begin wvalid = 1; w_up = 1; end
    while (!(aw_done && w_done)) begin
      bit aw_acc, w_acc;
      @(negedge clk_i);
      aw_acc = awvalid && awready;
      w_acc  = wvalid && wready;
      @(posedge clk_i); #1;
      if (aw_acc) begin awvalid = 0; aw_done = 1; end
      if (w_acc)  begin wvalid = 0; w_done = 1; end
      cyc++;
      if (cyc == 2 && !aw_up) begin awvalid = 1; aw_up = 1; end
      if (cyc == 2 && !w_up)  begin wvalid = 1; w_up = 1; end
    end
    do @(negedge clk_i); while (!bvalid);
    check(req, "bresp", 64'(bresp), 64'd0);
    @(posedge clk_i); #1;
  endtask

  task automatic axi_read(string req, int a);
    bit [31:0] exp;
    @(posedge clk_i); #1;
    araddr = 8'(a); arvalid = 1;
    do @(negedge clk_i); while (!arready);
    exp = model_read(a);
    check("R9", "fifo_pop_o", 64'(pop), 64'((a == 'h30) && !fempty));
    @(posedge clk_i); #1;
    arvalid = 0;
    @(negedge clk_i);
    check(req, "rvalid", 64'(rvalid), 64'd1);
    check(req, $sformatf("rdata@%0h", a), 64'(rdata), 64'(exp));
    check("R10", "rresp", 64'(rresp), 64'd0);
  endtask

  task automatic strobe(int which, int cycles);
    @(posedge clk_i); #1;
    case (which) 0: rsent = 1; 1: ovf = 1; 2: tmo = 1; 3: gf = 1; default: crc = 1; endcase
    repeat (cycles) @(posedge clk_i);
    #1;
    rsent = 0; ovf = 0; tmo = 0; gf = 0; crc = 0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1;
    repeat (2) @(posedge clk_i);

    // R1 reset state
    for (int a = 0; a <= 'h2C; a += 4) axi_read("R1", a);

    // R2 plain registers, all three handshake orders
    axi_write("R2", 'h08, 32'h0000_0000, 0);
    axi_write("R2", 'h0C, 32'hFFFF_BEEF, 1);
    axi_write("R2", 'h10, 32'h0000_0003, 2);
    axi_write("R2", 'h14, 32'h0000_1234, 0);
    axi_write("R2", 'h1C, 32'h0000_0ABC, 2);
    for (int a = 8; a <= 'h20; a += 4) axi_read("R2", a);

    // R3 preset load, several codes
    axi_write("R3", 'h00, 32'h0000_000F, 1);      // p=3, en, bidir
    axi_read("R3", 'h14); axi_read("R3", 'h18); axi_read("R3", 'h20);
    axi_write("R3", 'h00, 32'h0000_001C, 0);      // p=7
    axi_read("R3", 'h1C); axi_read("R3", 'h00);

    // R4 preserve timing
    axi_write("R4", 'h18, 32'h0000_0777, 0);
    axi_write("R4", 'h00, 32'h0000_0035, 2);      // keep=1, p=5, en
    axi_read("R4", 'h00); axi_read("R4", 'h18); axi_read("R4", 'h14);

    // R5 sticky set and live busy
    strobe(0, 1);
    repeat (3) @(posedge clk_i);
    axi_read("R5", 'h04);
    busy = 1;
    axi_read("R5", 'h04);
    busy = 0;
    strobe(2, 1);
    axi_read("R5", 'h04);

    // R7 interrupt and mirror
    axi_write("R7", 'h08, 32'h0000_0002, 0);
    repeat (2) @(posedge clk_i);
    axi_read("R7", 'h00);
    axi_write("R7", 'h08, 32'h0000_0001, 0);      // busy-only mask
    busy = 1; repeat (3) @(posedge clk_i); #1; busy = 0;
    repeat (2) @(posedge clk_i);

    // R6 write-one-to-clear, zero write no effect
    axi_write("R6", 'h04, 32'h0000_0000, 1);
    axi_read("R6", 'h04);
    axi_write("R6", 'h04, 32'h0000_0002, 2);
    axi_read("R6", 'h04);
    // set wins over clear: overflow held through the clear
    @(posedge clk_i); #1; ovf = 1;
    axi_write("R6", 'h04, 32'h0000_0004, 0);
    @(posedge clk_i); #1; ovf = 0;
    axi_read("R6", 'h04);
    axi_write("R6", 'h04, 32'h0000_000E, 0);
    axi_read("R6", 'h04);

    // R8 counters
    strobe(3, 3);
    strobe(4, 2);
    strobe(0, 1);
    axi_read("R8", 'h24); axi_read("R8", 'h28); axi_read("R8", 'h2C);
    axi_write("R8", 'h24, 32'h0000_0055, 0);
    axi_read("R8", 'h24);

    // R9 FIFO window
    head = 19'h5A5A5; fempty = 0; flevel = 6'd17;
    axi_read("R9", 'h30); axi_read("R9", 'h34); axi_read("R9", 'h38);
    fempty = 1; flevel = 0;
    axi_read("R9", 'h30); axi_read("R9", 'h34);
    ffull = 1; fempty = 0; flevel = 6'd32;
    axi_read("R9", 'h34); axi_read("R9", 'h38);
    ffull = 0; fempty = 1; flevel = 0;

    // R10 unmapped
    axi_write("R10", 'h3C, 32'hFFFF_FFFF, 1);
    axi_write("R10", 'h80, 32'hFFFF_FFFF, 2);
    axi_read("R10", 'h3C); axi_read("R10", 'h80); axi_read("R10", 'h08);
    axi_read("R10", 'h00);

    repeat (4) @(posedge clk_i);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R10 watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule